// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two W-bit ports, A and B, and moves data across them in either direction. Each direction owns a storage register, a capture strobe, a select and an output enable. A direction drives the far port either with the live value currently on its own side or with what its register last stored. Because the block lives inside a larger chip, each port is split into an input vector (the external driver), an output vector and a per-bit drive-enable vector instead of a true tri-state pin. Two instances side by side give a 16-bit path.

Everything is synchronous to one system clock. A capture strobe stands in for a rising edge of the corresponding capture clock. The value the block sees on a port is the external driver when the block is not driving that port, and the block's own output when it is. When both directions are live and both are enabled, the two ports reinforce each other. A keeper register then models the bus holding its last value.

Top module: `xcvr_reg_bus`

## Requirements
- R1: With `cap_ab` high at a rising clock edge, the A-to-B register loads the value seen on port A, whatever the selects and enables are.
- R2: With `cap_ba` high at a rising clock edge, the B-to-A register loads the value seen on port B, whatever the selects and enables are.
- R3: A select at 0 makes its direction drive the live value seen on the near port. A select at 1 makes it drive its register contents. The change takes effect in the same cycle.
- R4: `oe_ab` is active high. `b_drive` is all ones when `oe_ab` is 1 and all zeros when it is 0.
- R5: `oe_ba_n` is active low. `a_drive` is all ones when `oe_ba_n` is 0 and all zeros when it is 1.
- R6: With `oe_ab`=0 and `oe_ba_n`=1, neither port is driven, and both registers still capture the external values.
- R7: A register that captures from a port the block is driving stores the block's own output on that port, not the external input. Both registers may capture on the same edge, each taking the pre-edge values.
- R8: With both selects 0 and both directions enabled, both outputs equal the value seen on port A in the last cycle before this mode began. They hold that value while the mode lasts, and the external inputs have no effect.
- R9: With both selects 1 and both directions enabled, port B carries the A-to-B register and port A carries the B-to-A register.
- R10: `rst_n` low at a rising edge clears both registers and the keeper to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | W | External driver value on port A |
| b_in | input | W | External driver value on port B |
| cap_ab | input | 1 | Capture strobe for the A-to-B register |
| cap_ba | input | 1 | Capture strobe for the B-to-A register |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| oe_ab | input | 1 | Drive port B, active high |
| oe_ba_n | input | 1 | Drive port A, active low |
| a_out | output | W | Value driven onto port A |
| a_drive | output | W | Per-bit drive enable for port A |
| b_out | output | W | Value driven onto port B |
| b_drive | output | W | Per-bit drive enable for port B |

## Verification
The assertions assume that the strobes, selects and enables are synchronous levels held for a full cycle. They also assume that reset is asserted at the first clock edge. The capture checks look only at cycles after reset has been released. The bench changes every input on the falling edge and holds reset low for the opening cycles and for each later reset pulse. Random traffic mixes all sixteen select and enable combinations, so the loop, stored-cross and isolation modes are each entered and left many times. Directed cases cover capture from a driven port and keeper hold.

// File: rtl/xcvr_pkg.sv
// Shared helpers for the registered bus transceiver.
package xcvr_pkg;
    // Value present on a port: the block's own output while it drives, otherwise the external driver.
    function automatic logic [63:0] bus_view(input logic drv, input logic [63:0] own,
                                             input logic [63:0] ext);
        return drv ? own : ext;
    endfunction
endpackage

// File: rtl/xcvr_store.sv
// One direction's storage register.
// Loads d whenever cap is high at a clock edge. Assumes cap is a one-cycle
// synchronous strobe standing in for the capture clock edge.
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture on strobe, clear on synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (cap) q <= d;
    end

    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (q == $past(d)));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(q));
    p_reset_r10: assert property (@(posedge clk)
        !$past(rst_n) |-> (q == '0));
endmodule

// File: rtl/xcvr_keeper.sv
// Bus keeper for the loopback mode.
// Tracks the port A value every cycle outside the loop, and freezes it while
// both directions drive each other live.
module xcvr_keeper #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         loop_on,
    input  logic [W-1:0] track,
    output logic [W-1:0] q
);
    // Follow port A until the loop closes, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (!loop_on) q <= track;
    end

    p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        loop_on |=> $stable(q));
endmodule

// File: rtl/xcvr_path.sv
// Output path of one direction.
// Chooses stored or live data for the far port. When the near port is itself
// driven by the block, the live value is the other direction's output, so the
// loop is resolved here without a combinational cycle.
module xcvr_path #(
    parameter int W = 8
) (
    input  logic         sel,
    input  logic         oe,
    input  logic [W-1:0] own_stored,
    input  logic [W-1:0] near_ext,
    input  logic         near_drv,
    input  logic         near_sel,
    input  logic [W-1:0] near_stored,
    input  logic [W-1:0] keep,
    output logic [W-1:0] out,
    output logic [W-1:0] drive
);
    logic [W-1:0] live_val;

    // Value seen on the near port, resolved without feedback.
    always_comb begin
        if (!near_drv)     live_val = near_ext;
        else if (near_sel) live_val = near_stored;
        else               live_val = keep;
    end

    // Stored versus live selection for the far port.
    always_comb out = sel ? own_stored : live_val;

    // Every bit follows the direction's enable.
    always_comb drive = {W{oe}};
endmodule

// File: rtl/xcvr_reg_bus.sv
// Registered bidirectional bus transceiver, top level.
// One storage register per direction, live/stored select, active-high enable
// toward B and active-low enable toward A. Assumes a single system clock with
// capture strobes replacing the two capture clocks.
module xcvr_reg_bus #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         cap_ab,
    input  logic         cap_ba,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_drive,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_drive
);
    import xcvr_pkg::*;

    localparam int VW = 64;

    logic         drv_a;
    logic         drv_b;
    logic         loop_on;
    logic [W-1:0] q_ab;
    logic [W-1:0] q_ba;
    logic [W-1:0] keep_q;
    logic [W-1:0] seen_a;
    logic [W-1:0] seen_b;
    logic [VW-1:0] view_a;
    logic [VW-1:0] view_b;

    // Internal enables, both active high.
    always_comb begin
        drv_a   = ~oe_ba_n;
        drv_b   = oe_ab;
        loop_on = drv_a & drv_b & ~sel_ab & ~sel_ba;
    end

    // Port values as seen from inside, used for capture and keeping.
    always_comb begin
        view_a = bus_view(drv_a, VW'(a_out), VW'(a_in));
        view_b = bus_view(drv_b, VW'(b_out), VW'(b_in));
        seen_a = view_a[W-1:0];
        seen_b = view_b[W-1:0];
    end

    xcvr_store #(.W(W)) u_st_ab (
        .clk(clk), .rst_n(rst_n), .cap(cap_ab), .d(seen_a), .q(q_ab));
    xcvr_store #(.W(W)) u_st_ba (
        .clk(clk), .rst_n(rst_n), .cap(cap_ba), .d(seen_b), .q(q_ba));

    xcvr_keeper #(.W(W)) u_keep (
        .clk(clk), .rst_n(rst_n), .loop_on(loop_on), .track(seen_a), .q(keep_q));

    xcvr_path #(.W(W)) u_to_b (
        .sel(sel_ab), .oe(drv_b), .own_stored(q_ab),
        .near_ext(a_in), .near_drv(drv_a), .near_sel(sel_ba), .near_stored(q_ba),
        .keep(keep_q), .out(b_out), .drive(b_drive));
    xcvr_path #(.W(W)) u_to_a (
        .sel(sel_ba), .oe(drv_a), .own_stored(q_ba),
        .near_ext(b_in), .near_drv(drv_b), .near_sel(sel_ab), .near_stored(q_ab),
        .keep(keep_q), .out(a_out), .drive(a_drive));

    p_isolate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_ab && oe_ba_n) |-> (a_drive == '0 && b_drive == '0));
    p_cross_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_ab && !oe_ba_n && sel_ab && sel_ba) |-> (b_out == q_ab && a_out == q_ba));
    p_loop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_on && $past(loop_on)) |-> ($stable(a_out) && $stable(b_out) && a_out == b_out));
    p_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ab && oe_ab && oe_ba_n) |-> (b_out == a_in));
endmodule

// File: tb/tb_xcvr_reg_bus.sv
module tb_xcvr_reg_bus;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         cap_ab = 0, cap_ba = 0, sel_ab = 0, sel_ba = 0, oe_ab = 0, oe_ba_n = 1;
    logic [W-1:0] a_out, a_drive, b_out, b_drive;

    int checks = 0;
    int fails  = 0;

    // reference state
    logic [W-1:0] m_ab = '0, m_ba = '0, m_keep = '0;

    xcvr_reg_bus #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
        .a_out(a_out), .a_drive(a_drive), .b_out(b_out), .b_drive(b_drive));

    always #10 clk = ~clk;

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish (actual=timeout expected=done)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Resolve the two buses by repeated substitution.
    function automatic logic [2*W-1:0] resolve();
        logic [W-1:0] ea, eb;
        logic da, db;
        da = !oe_ba_n;
        db = oe_ab;
        if (da && db && !sel_ab && !sel_ba) return {m_keep, m_keep};
        ea = sel_ba ? m_ba : b_in;
        eb = sel_ab ? m_ab : a_in;
        for (int k = 0; k < 2; k++) begin
            if (!sel_ab) eb = da ? ea : a_in;
            if (!sel_ba) ea = db ? eb : b_in;
        end
        return {ea, eb};
    endfunction

    function automatic string mode_tag();
        if (!oe_ab && oe_ba_n) return "R6";
        if (oe_ab && !oe_ba_n && !sel_ab && !sel_ba) return "R8";
        if (oe_ab && !oe_ba_n && sel_ab && sel_ba) return "R9";
        return "R3";
    endfunction

    // Check outputs against the model, then clock once and advance the model.
    task automatic cycle();
        logic [2*W-1:0] r;
        logic [W-1:0] sa, sb;
        logic loop;
        #2;
        r = resolve();
        if (rst_n) begin
            chk("R4 b_drive", b_drive, {W{oe_ab}});
            chk("R5 a_drive", a_drive, {W{!oe_ba_n}});
            if (oe_ab)    chk({mode_tag(), " b_out"}, b_out, r[W-1:0]);
            if (!oe_ba_n) chk({mode_tag(), " a_out"}, a_out, r[2*W-1:W]);
        end
        sa = !oe_ba_n ? r[2*W-1:W] : a_in;
        sb = oe_ab ? r[W-1:0] : b_in;
        loop = oe_ab && !oe_ba_n && !sel_ab && !sel_ba;
        @(posedge clk);
        if (!rst_n) begin
            m_ab = '0; m_ba = '0; m_keep = '0;
        end else begin
            if (cap_ab) m_ab = sa;
            if (cap_ba) m_ba = sb;
            if (!loop)  m_keep = sa;
        end
        @(negedge clk);
    endtask

    task automatic mode(input logic oab, input logic oban, input logic sab, input logic sba);
        oe_ab = oab; oe_ba_n = oban; sel_ab = sab; sel_ba = sba;
    endtask

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        cycle(); cycle();
        rst_n = 1;
        // R10: reset state visible through stored-cross mode
        mode(1, 0, 1, 1);
        #1; chk("R10 b_out", b_out, 8'h00); chk("R10 a_out", a_out, 8'h00);
        cycle();
        // R1/R2/R6: capture both while isolated
        mode(0, 1, 1, 0); a_in = 8'h3C; b_in = 8'hC5; cap_ab = 1; cap_ba = 1;
        #1; chk("R6 b_drive", b_drive, 8'h00); chk("R6 a_drive", a_drive, 8'h00);
        cycle();
        cap_ab = 0; cap_ba = 0; mode(1, 0, 1, 1);
        #1; chk("R1 b_out", b_out, 8'h3C); chk("R2 a_out", a_out, 8'hC5);
        cycle();
        // R3: live A to B
        mode(1, 1, 0, 0); a_in = 8'h71;
        #1; chk("R3 b_out", b_out, 8'h71);
        cycle();
        // R7: capture from driven A takes own output
        mode(0, 0, 0, 1); a_in = 8'hEE; cap_ab = 1;
        cycle();
        cap_ab = 0; mode(1, 0, 1, 1);
        #1; chk("R7 b_out", b_out, 8'hC5);
        cycle();
        // R8: loop hold
        mode(1, 1, 0, 0); a_in = 8'h96;
        cycle();
        mode(1, 0, 0, 0); a_in = 8'h00; b_in = 8'hFF;
        #1; chk("R8 a_out", a_out, 8'h96); chk("R8 b_out", b_out, 8'h96);
        cycle();
        a_in = 8'h11;
        #1; chk("R8 a_out held", a_out, 8'h96); chk("R8 b_out held", b_out, 8'h96);
        cycle();
        // R4/R5: disables
        mode(0, 1, 0, 0);
        #1; chk("R5 a_drive off", a_drive, 8'h00); chk("R4 b_drive off", b_drive, 8'h00);
        cycle();
        // random traffic
        for (int i = 0; i < 2000; i++) begin
            a_in = W'($urandom); b_in = W'($urandom);
            cap_ab = 1'($urandom); cap_ba = 1'($urandom);
            if ($urandom_range(0, 3) != 0)
                mode(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            rst_n = ($urandom_range(0, 199) != 0);
            cycle();
        end
        rst_n = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule